// File: doc/BRIEF.md
# Binary Extension Field Multiplier (Matrix Reduction)

This block multiplies two elements of GF(2^m) held in polynomial basis and returns their product reduced modulo a fixed irreducible polynomial. It is purely combinational: there is no clock and no state, and the output follows the operands after logic delay only. It suits datapaths such as elliptic-curve point arithmetic, Reed-Solomon codecs or authentication tags, where one field product is needed each cycle and the surrounding logic registers the result.

The carry-free product of the two operands has degree up to 2m-2. The block splits it into two parts. The low part holds the coefficients of degree 0 to m-1, and the high part holds the m-1 coefficients of degree m to 2m-2. Each high coefficient is folded back into the field through a constant matrix. Column j of that matrix is the residue of x^(m+j) modulo the polynomial, and it is worked out when the design elaborates. The folded value is XORed with the low part to form the result. The width and the polynomial are parameters, so a different field needs only a new instance.

Top module: `gf2m_matrix_mul`

## Requirements
- R1: For any operands, `prod` equals the carry-free product of `op_x` and `op_y` reduced modulo the parameter polynomial `POLY`. Bit k of each bus is the coefficient of x^k. `POLY` is M+1 bits wide with bit M set, and the defaults are M = 8 and POLY = 9'h11B.
- R2: If either operand is zero, `prod` is zero.
- R3: If one operand equals 1, `prod` equals the other operand.
- R4: Swapping `op_x` and `op_y` leaves `prod` unchanged.
- R5: When the degrees of the two operands sum to less than M, no reduction takes place and `prod` is the plain carry-free product.
- R6: With both operands all ones, the largest unreduced product, `prod` still equals the reduced product.
- R7: Multiplying x (value 2) by x^(M-1) (value 1 << (M-1)) gives the low M bits of `POLY`.
- R8: The multiplier is correct for parameter sets other than the default. The case M = 4, POLY = 5'h13 is covered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_x | input | M | First field operand, polynomial basis, bit k = coefficient of x^k |
| op_y | input | M | Second field operand, same encoding |
| prod | output | M | Reduced field product of op_x and op_y |

## Verification
Assertions inside the multiplier watch the algebraic identities that are visible at any moment: a zero operand, a unit operand, the no-reduction region for small operand degrees, and the single-column reduction of x times x^(M-1). Full correctness of the reduction matrix can only be shown by the bench. It sweeps every operand pair of the 8-bit field and of a 4-bit field against a shift-and-reduce model, checks commutativity across the sweep, and adds random pairs and the all-ones case.

// File: rtl/gf2m_matrix_mul.sv
module gf2m_matrix_mul #(
  parameter int       M    = 8,
  parameter logic [M:0] POLY = 9'h11B
) (
  input  logic [M-1:0] op_x,
  input  logic [M-1:0] op_y,
  output logic [M-1:0] prod
);

  localparam int HW = M - 1;
  localparam logic [M-1:0] TAIL = POLY[M-1:0];

  // residue of x^(M+j) modulo POLY
  function automatic logic [M-1:0] fold_col(input int j);
    logic [M-1:0] r;
    logic         top;
    r = TAIL;
    for (int k = 0; k < j; k++) begin
      top = r[M-1];
      r   = {r[M-2:0], 1'b0};
      if (top) r = r ^ TAIL;
    end
    return r;
  endfunction

  logic [M-1:0]  lo_part;
  logic [HW-1:0] hi_part;
  logic [M-1:0]  folded;
  logic [M-1:0]  masked [HW];

  always_comb begin
    lo_part = '0;
    hi_part = '0;
    for (int i = 0; i < M; i++) begin
      for (int k = 0; k < M; k++) begin
        if (i + k < M) lo_part[i+k]   = lo_part[i+k]   ^ (op_x[i] & op_y[k]);
        else           hi_part[i+k-M] = hi_part[i+k-M] ^ (op_x[i] & op_y[k]);
      end
    end
  end

  for (genvar j = 0; j < HW; j++) begin : g_col
    localparam logic [M-1:0] COL = fold_col(j);
    assign masked[j] = {M{hi_part[j]}} & COL;
  end

  always_comb begin
    folded = '0;
    for (int j = 0; j < HW; j++) folded = folded ^ masked[j];
  end

  assign prod = lo_part ^ folded;

  localparam logic [M-1:0] ONE   = M'(1);
  localparam logic [M-1:0] X1    = M'(2);
  localparam logic [M-1:0] XTOP  = M'(1) << (M - 1);
  localparam logic [M-1:0] XLIM  = M'(1) << (M / 2);
  localparam logic [M-1:0] YLIM  = M'(1) << ((M + 1) / 2);

  always_comb begin
    if (op_x == '0 || op_y == '0)
      assert_zero_operand_R2: assert (prod == '0);
    if (op_x == ONE)
      assert_unit_left_R3: assert (prod == op_y);
    if (op_y == ONE)
      assert_unit_right_R3: assert (prod == op_x);
    if (op_x < XLIM && op_y < YLIM)
      assert_no_fold_R5: assert (hi_part == '0 && prod == lo_part);
    if (op_x == X1 && op_y == XTOP)
      assert_first_column_R7: assert (prod == TAIL);
  end

endmodule

// File: tb/tb_gf2m_matrix_mul.sv
`timescale 1ns/1ps
module tb_gf2m_matrix_mul;

  localparam int M  = 8;
  localparam logic [M:0] POLY = 9'h11B;
  localparam int MS = 4;
  localparam logic [MS:0] POLYS = 5'h13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [M-1:0]  x, y, p;
  logic [MS-1:0] xs, ys, ps;

  gf2m_matrix_mul #(.M(M), .POLY(POLY)) dut (.op_x(x), .op_y(y), .prod(p));
  gf2m_matrix_mul #(.M(MS), .POLY(POLYS)) dut_small (.op_x(xs), .op_y(ys), .prod(ps));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [M-1:0] table_r [65536];

  function automatic int ref_mul(input int a, input int b, input int m, input int poly);
    int acc = 0;
    int sh  = a;
    for (int k = 0; k < m; k++) begin
      if (((b >> k) & 1) != 0) acc = acc ^ sh;
      sh = sh << 1;
      if (((sh >> m) & 1) != 0) sh = sh ^ poly;
    end
    return acc;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input int a, input int b);
    @(posedge clk);
    x <= M'(a);
    y <= M'(b);
    @(negedge clk);
  endtask

  task automatic apply_s(input int a, input int b);
    @(posedge clk);
    xs <= MS'(a);
    ys <= MS'(b);
    @(negedge clk);
  endtask

  initial begin
    x = '0; y = '0; xs = '0; ys = '0;
    repeat (4) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R2 after reset", int'(p), 0);

    // R1 and R4: exhaustive sweep of the 8-bit field
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        apply(a, b);
        table_r[a*256+b] = p;
        check("R1", int'(p), ref_mul(a, b, M, int'(POLY)));
        if (a > b) check("R4", int'(p), int'(table_r[b*256+a]));
      end
    end

    // R2 and R3 explicit corners
    for (int v = 0; v < 256; v += 17) begin
      apply(0, v);  check("R2", int'(p), 0);
      apply(v, 1);  check("R3", int'(p), v);
      apply(1, v);  check("R3", int'(p), v);
    end

    // R5: small degrees, no reduction
    apply(8'h0F, 8'h07); check("R5", int'(p), ref_mul(15, 7, 16, 0));
    apply(8'h09, 8'h0B); check("R5", int'(p), ref_mul(9, 11, 16, 0));

    // R6: all ones
    apply(8'hFF, 8'hFF); check("R6", int'(p), ref_mul(255, 255, M, int'(POLY)));

    // R7: x times x^(M-1)
    apply(2, 1 << (M-1)); check("R7", int'(p), int'(POLY) & 8'hFF);

    // R1 random vectors
    for (int n = 0; n < 300; n++) begin
      int ra, rb;
      ra = int'($urandom_range(255));
      rb = int'($urandom_range(255));
      apply(ra, rb);
      check("R1 random", int'(p), ref_mul(ra, rb, M, int'(POLY)));
    end

    // R8: second parameter set, exhaustive
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        apply_s(a, b);
        check("R8", int'(ps), ref_mul(a, b, MS, int'(POLYS)));
      end
    end
    apply_s(2, 8); check("R8 R7 small", int'(ps), 3);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule